// File: doc/BRIEF.md
# Dual-Clock Cell Header and Payload Splitter

This block is the entry stage of a cell receiver. Octets of fixed 69-octet cells arrive one per line-clock cycle, each cell marked by a start strobe on its first octet. The block counts octets within each cell, collects the five leading octets into a single 40-bit header word, and writes the 64 trailing octets into a payload store. Header words and payload octets each cross into the processor clock domain through their own asynchronous FIFO, built on Gray-coded pointers and two-flop synchronizers.

A cell is published to the reading side only once it is whole: the header word and the committed payload pointer advance on the same line-clock edge. The reading side waits for a header and 64 buffered payload octets, then presents the header together with the payload stream. The header stays on its output until the last payload octet has been taken. A cell that finds no room at its start strobe, or that is cut short by a new start strobe, is discarded whole, and a line-side counter records it.

Top module: `cell_splitter`

## Requirements
- R1: While either reset is held, `hdrValid` and `payValid` are low and `dropCount` is zero.
- R2: The header word carries the cell's first octet in bits 39:32, the second in bits 31:24, and so on, with the fifth in bits 7:0.
- R3: Payload octets come out in arrival order, 64 per cell. `payLast` is high with the 64th octet and only then.
- R4: `hdrValid` and `payValid` rise together, and neither falls until the 64th octet is accepted. The header word holds steady for the whole cell. Once started, the payload of a cell is never interrupted by missing data.
- R5: Line cycles with `inValid` low do not advance the octet count, so a cell may be delivered with idle gaps between its octets.
- R6: Octets marked valid with no start strobe, arriving while no cell is in progress, are discarded and leave the output and `dropCount` unchanged.
- R7: A start strobe that finds fewer than 64 free payload entries or no free header slot discards the whole cell and raises `dropCount` by one.
- R8: A start strobe that arrives before octet 68 of the current cell discards the partial cell, raises `dropCount` by one, and begins a new cell.
- R9: Cells sent back to back at one octet per line cycle are all delivered in arrival order when the reader keeps up.
- R10: While `payValid` is high and `payReady` is low, `payByte`, `payLast`, `hdrWord` and `payValid` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Line-side clock |
| wrRst_n | input | 1 | Line-side asynchronous reset, active low |
| inByte | input | 8 | Incoming cell octet |
| inValid | input | 1 | `inByte` carries an octet this cycle |
| inSoc | input | 1 | Current octet is the first octet of a cell |
| dropCount | output | DROP_W | Count of discarded cells, wrapping (line domain) |
| rdClk | input | 1 | Processor-side clock |
| rdRst_n | input | 1 | Processor-side asynchronous reset, active low |
| hdrWord | output | 40 | Header of the cell being delivered |
| hdrValid | output | 1 | `hdrWord` is valid |
| payByte | output | 8 | Payload octet of the current cell |
| payValid | output | 1 | `payByte` is valid |
| payLast | output | 1 | `payByte` is the cell's 64th payload octet |
| payReady | input | 1 | Reader accepts `payByte` this cycle |

## Verification
Unbroken back-to-back cells with distinct headers and payload seeds show octet steering, header packing and ordering. Cells with idle gaps and loose octets between cells separate a counter that advances on every cycle, or on unstarted octets, from a correct one. A truncated cell followed at once by a full one shows the rewind of partial payload. A stalled reader facing six cells separates whole-cell dropping from partial writes, and a periodic `payReady` pattern shows whether the outputs hold while the reader is stalled.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int HDR_OCTETS  = 5;
  localparam int PAY_OCTETS  = 64;
  localparam int CELL_OCTETS = HDR_OCTETS + PAY_OCTETS;
  localparam int HDR_W       = HDR_OCTETS * 8;
  localparam int CELL_SH     = $clog2(PAY_OCTETS);

  // line-side strobes from control to datapath
  typedef struct packed {
    logic hdrShift;
    logic payWrite;
    logic commit;
    logic rewind;
  } wrCmd_t;

  typedef struct packed {
    logic hdrRoom;
    logic payRoom;
  } wrStat_t;

  // processor-side strobes from control to datapath
  typedef struct packed {
    logic payRead;
    logic hdrPop;
  } rdCmd_t;

  typedef struct packed {
    logic cellReady;
    logic spare;
  } rdStat_t;
endpackage

// File: rtl/cs_gray_sync.sv
`timescale 1ns/1ps
module cs_gray_sync #(
  parameter int W = 4
) (
  input  logic         srcClk,
  input  logic         srcRst_n,
  input  logic [W-1:0] srcBin,
  input  logic         dstClk,
  input  logic         dstRst_n,
  output logic [W-1:0] dstBin
);
  logic [W-1:0] srcGray;
  logic [W-1:0] meta;
  logic [W-1:0] settled;

  always_ff @(posedge srcClk or negedge srcRst_n) begin
    if (!srcRst_n) srcGray <= '0;
    else           srcGray <= srcBin ^ (srcBin >> 1);
  end

  always_ff @(posedge dstClk or negedge dstRst_n) begin
    if (!dstRst_n) begin
      meta    <= '0;
      settled <= '0;
    end else begin
      meta    <= srcGray;
      settled <= meta;
    end
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bin
      assign dstBin[i] = ^settled[W-1:i];
    end
  endgenerate
endmodule

// File: rtl/cs_datapath.sv
`timescale 1ns/1ps
module cs_datapath
  import cs_pkg::*;
#(
  parameter int HDR_CELLS = 4,
  parameter int PAY_CELLS = 4
) (
  input  logic             wrClk,
  input  logic             wrRst_n,
  input  logic [7:0]       inByte,
  input  wrCmd_t           wrCmd,
  output wrStat_t          wrStat,
  input  logic             rdClk,
  input  logic             rdRst_n,
  input  rdCmd_t           rdCmd,
  output rdStat_t          rdStat,
  output logic [HDR_W-1:0] hdrWord,
  output logic [7:0]       payByte
);
  localparam int PAY_DEPTH = PAY_CELLS * PAY_OCTETS;
  localparam int HAW       = $clog2(HDR_CELLS);
  localparam int PAW       = $clog2(PAY_DEPTH);
  localparam int CW        = PAW - CELL_SH + 1;
  localparam logic [HAW:0] HDR_LIMIT = (HAW+1)'(HDR_CELLS);
  localparam logic [PAW:0] PAY_LIMIT = (PAW+1)'(PAY_DEPTH - PAY_OCTETS);
  localparam logic [PAW:0] CELL_BYTES = (PAW+1)'(PAY_OCTETS);

  logic [HDR_W-1:0] hdrShiftReg;
  logic [HDR_W-1:0] hdrMem [HDR_CELLS];
  logic [7:0]       payMem [PAY_DEPTH];

  logic [HAW:0] hdrWp, hdrRp, hdrRpW, hdrWpR;
  logic [PAW:0] paySpec, payCommit, payRp, payRpW, payCommitR;
  logic [CW-1:0] commitCellsR;

  // ---------------- line side ----------------
  always_ff @(posedge wrClk) begin
    if (wrCmd.hdrShift) hdrShiftReg <= {hdrShiftReg[HDR_W-9:0], inByte};
    if (wrCmd.payWrite) payMem[paySpec[PAW-1:0]] <= inByte;
    if (wrCmd.commit)   hdrMem[hdrWp[HAW-1:0]] <= hdrShiftReg;
  end

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n) begin
      hdrWp     <= '0;
      paySpec   <= '0;
      payCommit <= '0;
    end else begin
      if (wrCmd.rewind)        paySpec <= payCommit;
      else if (wrCmd.payWrite) paySpec <= paySpec + 1'b1;
      if (wrCmd.commit) begin
        payCommit <= paySpec + 1'b1;
        hdrWp     <= hdrWp + 1'b1;
      end
    end
  end

  logic [HAW:0] hdrUsed;
  logic [PAW:0] payUsed;
  assign hdrUsed        = hdrWp - hdrRpW;
  assign payUsed        = payCommit - payRpW;
  assign wrStat.hdrRoom = hdrUsed < HDR_LIMIT;
  assign wrStat.payRoom = payUsed <= PAY_LIMIT;

  // ---------------- processor side ----------------
  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) begin
      hdrRp <= '0;
      payRp <= '0;
    end else begin
      if (rdCmd.payRead) payRp <= payRp + 1'b1;
      if (rdCmd.hdrPop)  hdrRp <= hdrRp + 1'b1;
    end
  end

  logic [PAW:0] payAvail;
  assign payCommitR       = {commitCellsR, {CELL_SH{1'b0}}};
  assign payAvail         = payCommitR - payRp;
  assign rdStat.cellReady = (hdrWpR != hdrRp) && (payAvail >= CELL_BYTES);
  assign rdStat.spare     = 1'b0;

  assign hdrWord = hdrMem[hdrRp[HAW-1:0]];
  assign payByte = payMem[payRp[PAW-1:0]];

  // ---------------- pointer crossings ----------------
  cs_gray_sync #(.W(HAW+1)) i_hdrWpSync (
    .srcClk(wrClk), .srcRst_n(wrRst_n), .srcBin(hdrWp),
    .dstClk(rdClk), .dstRst_n(rdRst_n), .dstBin(hdrWpR));

  // committed payload pointer moves a whole cell at a time: cross the cell count
  cs_gray_sync #(.W(CW)) i_payCommitSync (
    .srcClk(wrClk), .srcRst_n(wrRst_n), .srcBin(payCommit[PAW:CELL_SH]),
    .dstClk(rdClk), .dstRst_n(rdRst_n), .dstBin(commitCellsR));

  cs_gray_sync #(.W(HAW+1)) i_hdrRpSync (
    .srcClk(rdClk), .srcRst_n(rdRst_n), .srcBin(hdrRp),
    .dstClk(wrClk), .dstRst_n(wrRst_n), .dstBin(hdrRpW));

  cs_gray_sync #(.W(PAW+1)) i_payRpSync (
    .srcClk(rdClk), .srcRst_n(rdRst_n), .srcBin(payRp),
    .dstClk(wrClk), .dstRst_n(wrRst_n), .dstBin(payRpW));
endmodule

// File: rtl/cs_ctrl.sv
`timescale 1ns/1ps
module cs_ctrl
  import cs_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input  logic              wrClk,
  input  logic              wrRst_n,
  input  logic              inValid,
  input  logic              inSoc,
  input  wrStat_t           wrStat,
  output wrCmd_t            wrCmd,
  output logic [DROP_W-1:0] dropCount,
  input  logic              rdClk,
  input  logic              rdRst_n,
  input  rdStat_t           rdStat,
  input  logic              payReady,
  output rdCmd_t            rdCmd,
  output logic              cellActive,
  output logic              payLast
);
  localparam int IDX_W = $clog2(CELL_OCTETS);
  localparam int BYTE_W = $clog2(PAY_OCTETS);
  localparam logic [IDX_W-1:0]  LAST_OCT  = IDX_W'(CELL_OCTETS - 1);
  localparam logic [IDX_W-1:0]  HDR_END   = IDX_W'(HDR_OCTETS);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAY_OCTETS - 1);

  // ---------------- line-side framing ----------------
  logic             wrActive;
  logic [IDX_W-1:0] octIdx;
  logic             startOk;

  assign startOk = wrStat.hdrRoom && wrStat.payRoom;

  always_comb begin
    wrCmd = '0;
    if (inValid) begin
      if (inSoc) begin
        wrCmd.rewind   = wrActive;
        wrCmd.hdrShift = startOk;
      end else if (wrActive) begin
        wrCmd.hdrShift = octIdx < HDR_END;
        wrCmd.payWrite = octIdx >= HDR_END;
        wrCmd.commit   = octIdx == LAST_OCT;
      end
    end
  end

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n) begin
      wrActive  <= 1'b0;
      octIdx    <= '0;
      dropCount <= '0;
    end else if (inValid) begin
      if (inSoc) begin
        wrActive  <= startOk;
        octIdx    <= IDX_W'(1);
        dropCount <= dropCount + DROP_W'(wrActive) + DROP_W'(!startOk);
      end else if (wrActive) begin
        if (octIdx == LAST_OCT) wrActive <= 1'b0;
        octIdx <= octIdx + 1'b1;
      end
    end
  end

  // ---------------- processor-side release ----------------
  logic              rdActive;
  logic [BYTE_W-1:0] byteIdx;

  always_comb begin
    rdCmd         = '0;
    rdCmd.payRead = rdActive && payReady;
    rdCmd.hdrPop  = rdActive && payReady && (byteIdx == LAST_BYTE);
  end

  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) begin
      rdActive <= 1'b0;
      byteIdx  <= '0;
    end else if (!rdActive) begin
      if (rdStat.cellReady) begin
        rdActive <= 1'b1;
        byteIdx  <= '0;
      end
    end else if (payReady) begin
      byteIdx <= byteIdx + 1'b1;
      if (byteIdx == LAST_BYTE) rdActive <= 1'b0;
    end
  end

  assign cellActive = rdActive;
  assign payLast    = rdActive && (byteIdx == LAST_BYTE);
endmodule

// File: rtl/cell_splitter.sv
`timescale 1ns/1ps
module cell_splitter #(
  parameter int HDR_CELLS = 4,
  parameter int PAY_CELLS = 4,
  parameter int DROP_W    = 16
) (
  input  logic                      wrClk,
  input  logic                      wrRst_n,
  input  logic [7:0]                inByte,
  input  logic                      inValid,
  input  logic                      inSoc,
  output logic [DROP_W-1:0]         dropCount,
  input  logic                      rdClk,
  input  logic                      rdRst_n,
  output logic [cs_pkg::HDR_W-1:0]  hdrWord,
  output logic                      hdrValid,
  output logic [7:0]                payByte,
  output logic                      payValid,
  output logic                      payLast,
  input  logic                      payReady
);
  cs_pkg::wrCmd_t  wrCmd;
  cs_pkg::wrStat_t wrStat;
  cs_pkg::rdCmd_t  rdCmd;
  cs_pkg::rdStat_t rdStat;
  logic            cellActive;

  cs_ctrl #(.DROP_W(DROP_W)) i_ctrl (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .inValid(inValid), .inSoc(inSoc),
    .wrStat(wrStat), .wrCmd(wrCmd), .dropCount(dropCount),
    .rdClk(rdClk), .rdRst_n(rdRst_n), .rdStat(rdStat), .payReady(payReady),
    .rdCmd(rdCmd), .cellActive(cellActive), .payLast(payLast));

  cs_datapath #(.HDR_CELLS(HDR_CELLS), .PAY_CELLS(PAY_CELLS)) i_dp (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .inByte(inByte), .wrCmd(wrCmd), .wrStat(wrStat),
    .rdClk(rdClk), .rdRst_n(rdRst_n), .rdCmd(rdCmd), .rdStat(rdStat),
    .hdrWord(hdrWord), .payByte(payByte));

  assign hdrValid = cellActive;
  assign payValid = cellActive;
endmodule

// File: rtl/cell_splitter_chk.sv
`timescale 1ns/1ps
module cell_splitter_chk #(
  parameter int DROP_W = 16
) (
  input logic              wrClk,
  input logic              wrRst_n,
  input logic [DROP_W-1:0] dropCount,
  input logic              rdClk,
  input logic              rdRst_n,
  input logic [39:0]       hdrWord,
  input logic              hdrValid,
  input logic [7:0]        payByte,
  input logic              payValid,
  input logic              payLast,
  input logic              payReady
);
  // R1: quiet outputs while held in reset
  always @(posedge rdClk) begin
    if (!rdRst_n) p_idle_out_r1: assert (!payValid && !hdrValid);
  end
  always @(posedge wrClk) begin
    if (!wrRst_n) p_idle_cnt_r1: assert (dropCount == '0);
  end

  // R3: last marker only inside a delivered cell
  p_last_in_cell_r3: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    payLast |-> (payValid && hdrValid));

  // R4: header stays put and the cell keeps going until its last octet
  p_hdr_steady_r4: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    (payValid && !payLast) |=> (hdrValid && payValid && $stable(hdrWord)));

  // R10: a stalled transfer keeps its data
  p_stall_hold_r10: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    (payValid && !payReady) |=> (payValid && $stable(payByte) && $stable(payLast) && $stable(hdrWord)));

  // R7 / R8: the drop count moves by at most two per start strobe
  p_drop_step_r7: assert property (@(posedge wrClk) disable iff (!wrRst_n)
    DROP_W'(dropCount - $past(dropCount)) <= DROP_W'(2));
endmodule

bind cell_splitter cell_splitter_chk #(.DROP_W(DROP_W)) i_chk (
  .wrClk(wrClk), .wrRst_n(wrRst_n), .dropCount(dropCount),
  .rdClk(rdClk), .rdRst_n(rdRst_n), .hdrWord(hdrWord), .hdrValid(hdrValid),
  .payByte(payByte), .payValid(payValid), .payLast(payLast), .payReady(payReady));

// File: tb/test_cell_splitter.sv
`timescale 1ns/1ps
module test_cell_splitter;
  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        wrRst_n = 1'b0, rdRst_n = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0, inSoc = 1'b0;
  logic [15:0] dropCount;
  logic [39:0] hdrWord;
  logic        hdrValid, payValid, payLast;
  logic [7:0]  payByte;
  logic        payReady = 1'b0;

  always #5 rdClk = ~rdClk;   // 100 MHz reader
  always #7 wrClk = ~wrClk;   // unrelated line clock

  cell_splitter i_cell_splitter (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .inByte(inByte), .inValid(inValid), .inSoc(inSoc),
    .dropCount(dropCount), .rdClk(rdClk), .rdRst_n(rdRst_n), .hdrWord(hdrWord),
    .hdrValid(hdrValid), .payByte(payByte), .payValid(payValid), .payLast(payLast),
    .payReady(payReady));

  int checks = 0, errors = 0, expDrop = 0;
  bit done = 1'b0;
  int readyMode = 0;   // 0 always, 1 periodic, 2 stalled
  logic [39:0] expHdr[$];
  logic [7:0]  expPay[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference reader, compared on every processor clock ----------------
  int pos = 0, rdCyc = 0;
  bit holdPending = 1'b0;
  logic [7:0]  heldByte;
  logic [39:0] heldHdr;
  always @(negedge rdClk) begin
    if (rdRst_n && !done) begin
      bit nextReady;
      rdCyc++;
      check(hdrValid == payValid, "R4", "valid pairing", hdrValid, payValid);
      if (holdPending)
        check(payValid && payByte == heldByte && hdrWord == heldHdr, "R10", "stall hold",
              payByte, heldByte);
      if (pos > 0) check(payValid, "R4", "cell interrupted", payValid, 1);
      nextReady = (readyMode == 0) || (readyMode == 1 && (rdCyc % 4) != 1);
      payReady  = nextReady;
      if (payValid && nextReady) begin
        if (expPay.size() == 0 || expHdr.size() == 0) begin
          check(1'b0, "R9", "unexpected octet", payByte, 0);
        end else begin
          logic [7:0] eb;
          eb = expPay.pop_front();
          check(payByte == eb, "R3", "payload octet", payByte, eb);
          check(hdrWord == expHdr[0], "R2", "header word", hdrWord, expHdr[0]);
          check(payLast == (pos == 63), "R3", "last marker", payLast, pos == 63);
          pos++;
          if (pos == 64) begin
            pos = 0;
            void'(expHdr.pop_front());
          end
        end
      end
      holdPending = payValid && !nextReady;
      heldByte    = payByte;
      heldHdr     = hdrWord;
    end
  end

  // ---------------- line-side stimulus ----------------
  task automatic putOctet(input logic [7:0] b, input logic soc);
    inByte = b; inSoc = soc; inValid = 1'b1;
    @(negedge wrClk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0; inSoc = 1'b0; inByte = 8'h00;
    repeat (n) @(negedge wrClk);
  endtask

  task automatic sendCell(input logic [39:0] hdr, input logic [7:0] seed,
                          input bit gaps, input bit keep);
    if (keep) begin
      expHdr.push_back(hdr);
      for (int k = 0; k < 64; k++) expPay.push_back(8'(seed + k));
    end
    for (int i = 0; i < 69; i++) begin
      logic [7:0] b;
      b = (i < 5) ? hdr[39 - 8*i -: 8] : 8'(seed + i - 5);
      putOctet(b, i == 0);
      if (gaps && (i % 7) == 3) idle(2);
    end
  endtask

  task automatic waitDrain();
    int n = 0;
    while (expHdr.size() != 0 && n < 20000) begin
      @(negedge rdClk);
      n++;
    end
    check(expHdr.size() == 0, "R9", "cells outstanding", expHdr.size(), 0);
    repeat (10) @(negedge wrClk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge rdClk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge wrClk);
    check(!hdrValid && !payValid, "R1", "valid in reset", {hdrValid, payValid}, 0);
    check(dropCount == 0, "R1", "drop count in reset", dropCount, 0);
    wrRst_n = 1'b1;
    rdRst_n = 1'b1;
    idle(5);

    // R9, R2, R3: back-to-back cells, reader always ready
    readyMode = 0;
    for (int c = 0; c < 4; c++) sendCell(40'hA1B2C3D400 + c, 8'(16*c), 1'b0, 1'b1);
    idle(3);
    waitDrain();

    // R5: idle gaps inside cells
    sendCell(40'h0102030405, 8'h80, 1'b1, 1'b1);
    sendCell(40'hF0E0D0C0B0, 8'h33, 1'b1, 1'b1);
    idle(3);
    waitDrain();

    // R6 and R10: loose octets, then a cell, reader pattern stalls
    readyMode = 1;
    for (int i = 0; i < 12; i++) putOctet(8'hEE, 1'b0);
    sendCell(40'h5566778899, 8'h40, 1'b0, 1'b1);
    for (int i = 0; i < 9; i++) putOctet(8'hDD, 1'b0);
    idle(3);
    waitDrain();
    check(dropCount == 16'(expDrop), "R6", "drops after loose octets", dropCount, expDrop);

    // R8: truncated cell followed at once by a full one
    putOctet(8'h99, 1'b1);
    for (int i = 0; i < 30; i++) putOctet(8'h77, 1'b0);
    expDrop++;
    sendCell(40'h123456789A, 8'h10, 1'b0, 1'b1);
    idle(3);
    waitDrain();
    check(dropCount == 16'(expDrop), "R8", "drops after truncation", dropCount, expDrop);

    // R7: reader stalled, six cells against room for four
    readyMode = 2;
    for (int c = 0; c < 6; c++) sendCell(40'hC0FFEE0000 + c, 8'(7*c), 1'b0, c < 4);
    expDrop += 2;
    idle(20);
    check(dropCount == 16'(expDrop), "R7", "drops when full", dropCount, expDrop);
    check(expHdr.size() == 4, "R7", "cells held while stalled", expHdr.size(), 4);
    readyMode = 1;
    waitDrain();
    check(dropCount == 16'(expDrop), "R7", "final drop count", dropCount, expDrop);
    check(expPay.size() == 0, "R9", "payload outstanding", expPay.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule